// File: doc/BRIEF.md
# FIFO Almost-Flag Offset Programmer

This block sits beside a FIFO's pointer logic. It holds two threshold offsets: the near-empty offset X and the near-full offset Y. From these and the FIFO fill count it drives two active-low status flags: near-empty and near-full. The FIFO memory and its pointers are outside the block. They supply the current fill count and the write strobe with its data.

The loading method is chosen once, on the last clock of master reset, from a mode pin and a two-bit select bus. There are three methods:

- Preset: one of three fixed values goes into both offsets.
- Parallel: the first two writes after reset carry the offsets, Y first and then X. The block tells the write path that these writes are consumed and must not be stored.
- Serial: the select bus doubles as a serial data bit and a shift enable, and the offsets are shifted in MSB first, Y first and then X.

A partial reset only clears the flags. The offsets, the chosen method and any loading progress survive it.

Top module: `fifo_ofs_prog`

## Requirements
- R1: While `rst_n` is low, while `prst_n` is low, and while `ofs_valid` is low, the flags are forced so that `ae_n` reads 0 and `af_n` reads 1 at the next clock, whatever the fill count.
- R2: The method is taken from `prog_mode` and `ofs_sel` at the last rising clock with `rst_n` low. Changing these pins afterwards does not change the method or a preset offset.
- R3: With `prog_mode`=1, `ofs_sel`=2'b11 loads 64, 2'b10 loads 16 and 2'b01 loads 8 into both X and Y. In this case `ofs_valid` is 1 from the first cycle after reset.
- R4: With `prog_mode`=1 and `ofs_sel`=2'b00 (parallel), the first write after reset loads `wr_data` into Y and the second loads it into X. `wr_consume` is high, combinationally, during exactly those two write cycles. `ofs_valid` rises at the clock of the second write.
- R5: With `prog_mode`=0 (serial), `ofs_sel[1]` is the shift enable and `ofs_sel[0]` is the data bit. On each enabled clock one bit enters, MSB first, Y's bits first and then X's. `ofs_valid` rises at the clock of bit 2*OW. Bits on cycles with the enable low, and bits after loading completes, are ignored.
- R6: Once `ofs_valid` is 1, `ae_n` is registered one clock after `fill_cnt`. It is 0 when `fill_cnt` <= X and 1 otherwise.
- R7: Once `ofs_valid` is 1, `af_n` is registered one clock after `fill_cnt`. It is 0 when DEPTH - `fill_cnt` <= Y and 1 otherwise.
- R8: A partial reset leaves X, Y, the method and the loading progress unchanged. Serial bits and writes seen while `prst_n` is low are ignored.
- R9: In preset and serial methods, `wr_consume` stays 0 for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset; method is sampled while low |
| prst_n | input | 1 | Synchronous active-low partial reset; clears flags only |
| prog_mode | input | 1 | 1: preset or parallel method, 0: serial method |
| ofs_sel | input | 2 | Preset select; in serial method bit 1 = enable, bit 0 = data |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | OW | Offset field of the FIFO write data |
| fill_cnt | input | CW | Words currently held in the FIFO (0..DEPTH) |
| wr_consume | output | 1 | Current write programs an offset and must not be stored |
| ofs_valid | output | 1 | Both offsets loaded; flags are live |
| ae_n | output | 1 | Near-empty flag, active low |
| af_n | output | 1 | Near-full flag, active low |

## Verification
The bench probes each threshold on both sides: the count equal to the offset and the count one past it. An off-by-one comparison, or comparing the fill count instead of the free space for near-full, shows up as a wrong flag level. It swaps the pins right after reset is released, interrupts a serial load halfway with a partial reset, and sends extra serial bits after loading. A design that samples the method late, lets partial reset wipe progress, or keeps shifting would end with the wrong thresholds. It also counts the consumed writes in parallel mode: three writes where only two are consumed catch a counter that never stops. Writes in serial mode and after a partial reset catch a consume signal that is not gated by the method.

// File: rtl/fifo_ofs_pkg.sv
// Package: shared types and helpers for the FIFO offset programmer.
// Assumes: callers size preset values to an offset width of at least 7 bits.
package fifo_ofs_pkg;

    typedef enum logic [1:0] {
        LM_PRESET   = 2'd0,
        LM_PARALLEL = 2'd1,
        LM_SERIAL   = 2'd2
    } load_mode_e;

    // Decode mode pin and select bus into a loading method.
    function automatic load_mode_e decode_mode(input logic mode, input logic [1:0] sel);
        if (!mode)
            return LM_SERIAL;
        else if (sel == 2'b00)
            return LM_PARALLEL;
        else
            return LM_PRESET;
    endfunction

    // Preset offset picked by the select bus (meaningful only in preset method).
    function automatic int unsigned preset_value(input logic [1:0] sel);
        case (sel)
            2'b11:   return 64;
            2'b10:   return 16;
            2'b01:   return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fofs_cfg_latch.sv
// Module: captures the loading method while master reset is held low.
// The value held at the last reset clock stays fixed until the next master
// reset. Also presents the decode of the live pins for use during reset.
// Assumes: rst_n is synchronous and active low.
module fofs_cfg_latch
    import fifo_ofs_pkg::*;
#(
    parameter int OW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_mode,
    input  logic [1:0]       ofs_sel,
    output load_mode_e       method,
    output load_mode_e       pin_method,
    output logic [OW-1:0]    pin_preset
);

    // Decode of the live pins.
    always_comb begin
        pin_method = decode_mode(prog_mode, ofs_sel);
        pin_preset = OW'(preset_value(ofs_sel));
    end

    // Track the pins during reset; freeze once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            method <= pin_method;
    end

endmodule

// File: rtl/fofs_loader.sv
// Module: owns the X (near-empty) and Y (near-full) offset registers and
// loads them by preset, by two parallel writes (Y then X) or by a serial
// MSB-first stream (Y then X). Reports when loading is complete and when a
// write is consumed for programming.
// Assumes: partial reset freezes all loading activity without clearing it.
module fofs_loader
    import fifo_ofs_pkg::*;
#(
    parameter int OW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  load_mode_e       method,
    input  load_mode_e       pin_method,
    input  logic [OW-1:0]    pin_preset,
    input  logic             ser_en,
    input  logic             ser_bit,
    input  logic             wr_en,
    input  logic [OW-1:0]    wr_data,
    output logic [OW-1:0]    x_ofs,
    output logic [OW-1:0]    y_ofs,
    output logic             loaded,
    output logic             wr_consume
);

    localparam int BITS = 2 * OW;
    localparam int CNTW = $clog2(BITS + 1);

    logic [CNTW-1:0] step;
    logic            active;

    // Loading may advance only outside both resets and before completion.
    assign active = rst_n && prst_n && !loaded;

    // A write is taken for programming only in parallel method before completion.
    assign wr_consume = active && wr_en && (method == LM_PARALLEL);

    // Offset registers, step counter and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step   <= '0;
            loaded <= (pin_method == LM_PRESET);
            if (pin_method == LM_PRESET) begin
                x_ofs <= pin_preset;
                y_ofs <= pin_preset;
            end else begin
                x_ofs <= '0;
                y_ofs <= '0;
            end
        end else if (active) begin
            case (method)
                LM_PARALLEL: begin
                    if (wr_en) begin
                        if (step == '0) begin
                            y_ofs <= wr_data;
                        end else begin
                            x_ofs  <= wr_data;
                            loaded <= 1'b1;
                        end
                        step <= step + 1'b1;
                    end
                end
                LM_SERIAL: begin
                    if (ser_en) begin
                        {y_ofs, x_ofs} <= {y_ofs[OW-2:0], x_ofs, ser_bit};
                        step <= step + 1'b1;
                        if (step == CNTW'(BITS - 1))
                            loaded <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fofs_flag_gen.sv
// Module: registered near-empty / near-full flags from the fill count.
// Near-empty (active low) when fill <= X; near-full (active low) when
// free space <= Y. Both are held inactive-safe (ae_n=0, af_n=1) in reset,
// partial reset and until the offsets are loaded.
// Assumes: fill_cnt never exceeds DEPTH.
module fofs_flag_gen #(
    parameter int DEPTH = 256,
    parameter int OW    = 8,
    parameter int CW    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             ofs_valid,
    input  logic [CW-1:0]    fill_cnt,
    input  logic [OW-1:0]    x_ofs,
    input  logic [OW-1:0]    y_ofs,
    output logic             ae_n,
    output logic             af_n
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0] free_cnt;
    logic          near_empty;
    logic          near_full;

    // Threshold comparisons against the zero-extended offsets.
    always_comb begin
        free_cnt   = DEPTH_C - fill_cnt;
        near_empty = (fill_cnt <= CW'(x_ofs));
        near_full  = (free_cnt <= CW'(y_ofs));
    end

    // Register the flags, forcing the safe levels when not live.
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n || !ofs_valid) begin
            ae_n <= 1'b0;
            af_n <= 1'b1;
        end else begin
            ae_n <= !near_empty;
            af_n <= !near_full;
        end
    end

endmodule

// File: rtl/fifo_ofs_prog.sv
// Module: top of the FIFO near-empty / near-full offset programmer.
// Latches the loading method in master reset, loads the two offsets and
// drives the two flags from the supplied fill count.
// Assumes: single clock; the write path honours wr_consume by not storing.
module fifo_ofs_prog
    import fifo_ofs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             prog_mode,
    input  logic [1:0]       ofs_sel,
    input  logic             wr_en,
    input  logic [OW-1:0]    wr_data,
    input  logic [CW-1:0]    fill_cnt,
    output logic             wr_consume,
    output logic             ofs_valid,
    output logic             ae_n,
    output logic             af_n
);

    load_mode_e     method;
    load_mode_e     pin_method;
    logic [OW-1:0]  pin_preset;
    logic [OW-1:0]  x_ofs;
    logic [OW-1:0]  y_ofs;

    fofs_cfg_latch #(.OW(OW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_mode  (prog_mode),
        .ofs_sel    (ofs_sel),
        .method     (method),
        .pin_method (pin_method),
        .pin_preset (pin_preset)
    );

    fofs_loader #(.OW(OW)) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .prst_n     (prst_n),
        .method     (method),
        .pin_method (pin_method),
        .pin_preset (pin_preset),
        .ser_en     (ofs_sel[1]),
        .ser_bit    (ofs_sel[0]),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .x_ofs      (x_ofs),
        .y_ofs      (y_ofs),
        .loaded     (ofs_valid),
        .wr_consume (wr_consume)
    );

    fofs_flag_gen #(.DEPTH(DEPTH), .OW(OW), .CW(CW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .prst_n     (prst_n),
        .ofs_valid  (ofs_valid),
        .fill_cnt   (fill_cnt),
        .x_ofs      (x_ofs),
        .y_ofs      (y_ofs),
        .ae_n       (ae_n),
        .af_n       (af_n)
    );

endmodule

// File: rtl/fifo_ofs_prog_chk.sv
// Checker: temporal properties of the offset programmer, bound to the top.
module fifo_ofs_prog_chk
    import fifo_ofs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OW    = 8,
    parameter int CW    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    fill_cnt,
    input  logic             wr_consume,
    input  logic             ofs_valid,
    input  logic             ae_n,
    input  logic             af_n,
    input  load_mode_e       method,
    input  logic [OW-1:0]    x_ofs,
    input  logic [OW-1:0]    y_ofs
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    // R1: flags forced while partial reset or offsets not yet loaded
    p_forced_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!prst_n || !ofs_valid) |=> (!ae_n && af_n));

    // R2: method frozen once master reset is released
    p_method_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(method));

    // R4: consume only on a write before loading completes
    p_consume_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_consume |-> (wr_en && !ofs_valid && prst_n));

    // R9: no consume outside parallel method
    p_consume_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (method != LM_PARALLEL) |-> !wr_consume);

    // R8: loaded state survives partial reset and persists
    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_valid |=> ofs_valid);

    // R6: near-empty asserted one clock after fill reaches X
    p_ae_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_valid && fill_cnt <= CW'(x_ofs)) |=> !ae_n);

    // R7: near-full released one clock after free space exceeds Y
    p_af_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_valid && (DEPTH_C - fill_cnt) > CW'(y_ofs)) |=> af_n);

endmodule

bind fifo_ofs_prog fifo_ofs_prog_chk #(.DEPTH(DEPTH), .OW(OW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prst_n     (prst_n),
    .wr_en      (wr_en),
    .fill_cnt   (fill_cnt),
    .wr_consume (wr_consume),
    .ofs_valid  (ofs_valid),
    .ae_n       (ae_n),
    .af_n       (af_n),
    .method     (method),
    .x_ofs      (x_ofs),
    .y_ofs      (y_ofs)
);

// File: tb/fifo_ofs_prog_test.sv
// Directed bench for the offset programmer: one task per scenario.
module fifo_ofs_prog_test;

    localparam int DEPTH = 256;
    localparam int OW    = 8;
    localparam int CW    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          prog_mode = 1'b1;
    logic [1:0]    ofs_sel = 2'b11;
    logic          wr_en = 1'b0;
    logic [OW-1:0] wr_data = '0;
    logic [CW-1:0] fill_cnt = '0;
    logic          wr_consume, ofs_valid, ae_n, af_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fifo_ofs_prog #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .prog_mode(prog_mode),
        .ofs_sel(ofs_sel), .wr_en(wr_en), .wr_data(wr_data), .fill_cnt(fill_cnt),
        .wr_consume(wr_consume), .ofs_valid(ofs_valid), .ae_n(ae_n), .af_n(af_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Apply a fill count, let one clock pass, then compare both flags.
    task automatic chk_flags(input string tag, input int fill, input logic e_ae, input logic e_af);
        fill_cnt = CW'(fill);
        @(negedge clk);
        chk({tag, " ae_n"}, ae_n, e_ae);
        chk({tag, " af_n"}, af_n, e_af);
    endtask

    // Check both sides of both thresholds for offsets x and y.
    task automatic chk_thresholds(input string tag, input int x, input int y);
        chk_flags({tag, " fill=X"},        x,             1'b0, 1'b1);
        chk_flags({tag, " fill=X+1"},      x + 1,         1'b1, 1'b1);
        chk_flags({tag, " free=Y"},        DEPTH - y,     1'b1, 1'b0);
        chk_flags({tag, " free=Y+1"},      DEPTH - y - 1, 1'b1, 1'b1);
    endtask

    // Master reset with the given method pins; R1 checked while held.
    task automatic do_reset(input logic pm, input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0; prst_n = 1'b1; wr_en = 1'b0;
        prog_mode = pm; ofs_sel = sel; fill_cnt = CW'(100);
        repeat (3) @(negedge clk);
        chk("R1 reset ae_n", ae_n, 1'b0);
        chk("R1 reset af_n", af_n, 1'b1);
        rst_n = 1'b1;
    endtask

    // R3 / R2 / R9: presets, with pins scrambled after reset.
    task automatic t_preset(input logic [1:0] sel, input int val);
        do_reset(1'b1, sel);
        prog_mode = 1'b0; ofs_sel = 2'b11;     // would shift ones if serial
        wr_en = 1'b1; wr_data = 8'h3C;
        #1 chk("R9 preset no consume", wr_consume, 1'b0);
        @(negedge clk);
        chk("R3 preset valid", ofs_valid, 1'b1);
        repeat (3) @(negedge clk);
        wr_en = 1'b0; ofs_sel = 2'b00;
        chk_thresholds($sformatf("R3 R2 R6 R7 preset %0d", val), val, val);
    endtask

    // R4: parallel load Y then X, third write not consumed.
    task automatic t_parallel();
        do_reset(1'b1, 2'b00);
        chk("R4 not valid before writes", ofs_valid, 1'b0);
        chk_flags("R1 unloaded", 100, 1'b0, 1'b1);
        wr_en = 1'b1; wr_data = 8'd20;
        #1 chk("R4 consume first", wr_consume, 1'b1);
        @(negedge clk);
        chk("R4 valid after one write", ofs_valid, 1'b0);
        wr_data = 8'd5;
        #1 chk("R4 consume second", wr_consume, 1'b1);
        @(negedge clk);
        chk("R4 valid after two writes", ofs_valid, 1'b1);
        wr_data = 8'd99;
        #1 chk("R4 third write stored", wr_consume, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        chk_thresholds("R4 R6 R7 parallel", 5, 20);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int from, input int to);
        for (int i = from; i >= to; i--) begin
            ofs_sel = {1'b1, bits[i]};
            @(negedge clk);
            ofs_sel = {1'b0, ~bits[i]};       // disabled cycle carrying junk
            @(negedge clk);
        end
        ofs_sel = 2'b00;
    endtask

    // R5 / R8 / R9: serial load interrupted by partial reset, extra bits after.
    task automatic t_serial();
        logic [15:0] stream;
        stream = {8'd33, 8'd12};
        do_reset(1'b0, 2'b00);
        wr_en = 1'b1; wr_data = 8'hFF;
        #1 chk("R9 serial no consume", wr_consume, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        shift_bits(stream, 15, 8);
        prst_n = 1'b0; ofs_sel = 2'b11;
        repeat (2) @(negedge clk);
        ofs_sel = 2'b10;
        @(negedge clk);
        prst_n = 1'b1; ofs_sel = 2'b00;
        shift_bits(stream, 7, 1);
        chk("R5 not valid after 15 bits", ofs_valid, 1'b0);
        chk_flags("R1 serial unloaded", 100, 1'b0, 1'b1);
        shift_bits(stream, 0, 0);
        chk("R5 valid after 16 bits", ofs_valid, 1'b1);
        chk_thresholds("R5 R8 serial", 12, 33);
        shift_bits(16'hFFFF, 15, 0);
        chk_thresholds("R5 extra bits ignored", 12, 33);
    endtask

    // R8: partial reset after loading keeps offsets and method.
    task automatic t_partial();
        @(negedge clk);
        prst_n = 1'b0; fill_cnt = CW'(100);
        @(negedge clk);
        chk("R8 R1 prst ae_n", ae_n, 1'b0);
        chk("R8 R1 prst af_n", af_n, 1'b1);
        prst_n = 1'b1;
        wr_en = 1'b1; wr_data = 8'h01;
        #1 chk("R8 method kept no consume", wr_consume, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 still valid", ofs_valid, 1'b1);
        chk_thresholds("R8 after partial reset", 12, 33);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 initial ae_n", ae_n, 1'b0);
        chk("R1 initial af_n", af_n, 1'b1);
        t_preset(2'b11, 64);
        t_preset(2'b10, 16);
        t_preset(2'b01, 8);
        t_parallel();
        t_serial();
        t_partial();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule